// File: doc/BRIEF.md
# Ethernet MAC Interrupt Event Unit

This block collects the interrupt-worthy events of an Ethernet controller in a 32-bit event register and gates them with a 32-bit enable mask. Thirteen event bits are defined, packed into the top of the word. Each enabled event drives a dedicated interrupt line rather than sharing one combined request. Event sources elsewhere in the controller raise their bit with a one-cycle pulse. Software acknowledges an event by writing a one to its bit.

A small register bus has no handshake. There is one write strobe, an address, write data and a combinational read-data output. The bus covers the event and mask registers and three command locations: a management-frame write, a transmit-control write and a controller-reset write. These raise or clear events as side effects. A per-line record holds the last reported enabled state. A line is updated only when its enabled state differs from that record, so every line follows its enabled event one clock later. No data flows through the block, so all pins are plain control and status signals.

Top module: `eth_irq_unit`

## Requirements
- R1: Event bits sit at positions 31 down to 19 as: heartbeat 31, babbling receive 30, babbling transmit 29, graceful stop 28, transmit frame 27, transmit buffer 26, receive frame 25, receive buffer 24, management done 23, bus error 22, late collision 21, retry limit 20, underrun 19. Input `ev_pulse[i]` sets the event bit of line i (mapping in R5) at the next clock edge.
- R2: A write to address 0 (event register) clears every event bit written as one. Bits written as zero are unchanged. Reading address 0 returns the event register.
- R3: A write to address 1 replaces the mask register with the written value. Reading address 1 returns the mask register.
- R4: `irq_line[i]` is high exactly when the event bit and the mask bit of line i were both set one clock earlier. The line changes one clock after the event or mask change.
- R5: Lines 0 to 12 carry, in order, the bits 27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30.
- R6: Any write to address 2 (management frame) sets event bit 23.
- R7: A write to address 3 (transmit control) with data bit 0 set sets event bit 28. With bit 0 clear it has no effect on the event register.
- R8: A write to address 4 (controller control) with data bit 0 set clears both the event and mask registers. This takes priority over every set in the same cycle.
- R9: If an event is set by a pulse or command in the same cycle that a write-one-to-clear targets it, the bit ends up set.
- R10: Event and mask bits 18 down to 0 always read as zero and cannot be set.
- R11: Addresses 2 to 7 read as zero. Writes to addresses 5 to 7 change nothing.
- R12: After reset the event register, the mask register and all lines are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| ev_pulse | input | 13 | Event set pulses, indexed by line number |
| irq_line | output | 13 | Interrupt lines, one per event |

## Verification
The main pattern is random pulse vectors mixed with random writes over all eight addresses. The random writes are biased toward the event and mask registers. The comparison is made against a bench model every cycle. This separates a wrong line-to-bit map from a wrong clear rule or a missing one-cycle lag. Directed sequences then aim at single cases. Pulsing and clearing one bit in the same cycle exposes a clear that wins over a set. A controller reset issued together with pulses shows whether the reset takes priority. Transmit-control writes with bit 0 clear and writes to unused addresses show whether these have any effect. Writing all ones to both registers checks that the low bits stay at zero.

// File: rtl/eth_irq_pkg.sv
package eth_irq_pkg;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 3;
  localparam int NUM_LINES = 13;

  localparam logic [ADDR_W-1:0] A_EVENT = 3'd0;
  localparam logic [ADDR_W-1:0] A_MASK  = 3'd1;
  localparam logic [ADDR_W-1:0] A_MGMT  = 3'd2;
  localparam logic [ADDR_W-1:0] A_TXCTL = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd4;

  localparam int BIT_MGMT_DONE = 23;
  localparam int BIT_GSTOP     = 28;

  // Event bit position driven onto each output line
  function automatic int line_bit(input int line);
    case (line)
      0:       return 27;
      1:       return 26;
      2:       return 19;
      3:       return 20;
      4:       return 25;
      5:       return 24;
      6:       return 23;
      7:       return 21;
      8:       return 31;
      9:       return 28;
      10:      return 22;
      11:      return 29;
      default: return 30;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] defined_bits();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_LINES; i++) m[line_bit(i)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/eth_irq_decode.sv
module eth_irq_decode
  import eth_irq_pkg::*;
(
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  input  logic [NUM_LINES-1:0] ev_pulse,
  output logic [DATA_W-1:0]    clr_vec,
  output logic [DATA_W-1:0]    set_vec,
  output logic                 mask_we,
  output logic                 soft_rst
);
  logic [DATA_W-1:0] pulse_vec;

  always_comb begin
    pulse_vec = '0;
    for (int i = 0; i < NUM_LINES; i++)
      if (ev_pulse[i]) pulse_vec[line_bit(i)] = 1'b1;
  end

  always_comb begin
    set_vec = pulse_vec;
    if (bus_wr && bus_addr == A_MGMT) set_vec[BIT_MGMT_DONE] = 1'b1;
    if (bus_wr && bus_addr == A_TXCTL && bus_wdata[0]) set_vec[BIT_GSTOP] = 1'b1;
  end

  assign clr_vec  = (bus_wr && bus_addr == A_EVENT) ? bus_wdata : '0;
  assign mask_we  = bus_wr && bus_addr == A_MASK;
  assign soft_rst = bus_wr && bus_addr == A_CTRL && bus_wdata[0];
endmodule

// File: rtl/eth_irq_regs.sv
module eth_irq_regs
  import eth_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] clr_vec,
  input  logic [DATA_W-1:0] set_vec,
  input  logic              mask_we,
  input  logic [DATA_W-1:0] mask_wdata,
  input  logic              soft_rst,
  output logic [DATA_W-1:0] evt_q,
  output logic [DATA_W-1:0] msk_q
);
  localparam logic [DATA_W-1:0] KEEP = defined_bits();

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= '0;
      msk_q <= '0;
    end else if (soft_rst) begin
      evt_q <= '0;
      msk_q <= '0;
    end else begin
      evt_q <= ((evt_q & ~clr_vec) | set_vec) & KEEP;
      if (mask_we) msk_q <= mask_wdata & KEEP;
    end
  end
endmodule

// File: rtl/eth_irq_router.sv
module eth_irq_router
  import eth_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DATA_W-1:0]    active,
  output logic [NUM_LINES-1:0] irq_line
);
  logic [NUM_LINES-1:0] reported_q;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    localparam int SRC = line_bit(g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         reported_q[g] <= 1'b0;
      else if (active[SRC] != reported_q[g]) reported_q[g] <= active[SRC];
    end
  end

  assign irq_line = reported_q;
endmodule

// File: rtl/eth_irq_unit.sv
module eth_irq_unit
  import eth_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NUM_LINES-1:0] ev_pulse,
  output logic [NUM_LINES-1:0] irq_line
);
  logic [DATA_W-1:0] clr_vec, set_vec, evt_q, msk_q;
  logic              mask_we, soft_rst;

  eth_irq_decode u_dec (
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .ev_pulse(ev_pulse), .clr_vec(clr_vec), .set_vec(set_vec),
    .mask_we(mask_we), .soft_rst(soft_rst)
  );

  eth_irq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .clr_vec(clr_vec), .set_vec(set_vec),
    .mask_we(mask_we), .mask_wdata(bus_wdata), .soft_rst(soft_rst),
    .evt_q(evt_q), .msk_q(msk_q)
  );

  eth_irq_router u_route (
    .clk(clk), .rst_n(rst_n), .active(evt_q & msk_q), .irq_line(irq_line)
  );

  always_comb begin
    case (bus_addr)
      A_EVENT: bus_rdata = evt_q;
      A_MASK:  bus_rdata = msk_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/eth_irq_chk.sv
module eth_irq_chk
  import eth_irq_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_wr,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [DATA_W-1:0]    bus_wdata,
  input logic [NUM_LINES-1:0] ev_pulse,
  input logic [NUM_LINES-1:0] irq_line,
  input logic [DATA_W-1:0]    evt_q,
  input logic [DATA_W-1:0]    msk_q
);
  localparam logic [DATA_W-1:0] KEEP = defined_bits();
  logic wr_rst;
  assign wr_rst = bus_wr && bus_addr == A_CTRL && bus_wdata[0];

  // R10: low bits stay clear
  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_q | msk_q) & ~KEEP) == '0);

  // R3: mask write replaces the mask
  a_r3_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_MASK) |=> msk_q == ($past(bus_wdata) & KEEP));

  // R8: controller reset empties both registers
  a_r8_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rst |=> (evt_q == '0 && msk_q == '0));

  // R6: management frame write raises the done bit
  a_r6_mgmt_done: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_MGMT) |=> evt_q[BIT_MGMT_DONE]);

  // R9: a pulse on the management line wins over a clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pulse[6] && !wr_rst) |=> evt_q[BIT_MGMT_DONE]);

  // R4: the number of asserted lines follows the enabled events one clock later
  a_r4_line_count: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $countones(irq_line) == $countones($past(evt_q & msk_q)));
endmodule

bind eth_irq_unit eth_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .ev_pulse(ev_pulse), .irq_line(irq_line),
  .evt_q(evt_q), .msk_q(msk_q)
);

// File: tb/eth_irq_unit_test.sv
module eth_irq_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [12:0] ev_pulse = '0;
  logic [12:0] irq_line;

  int tests = 0, fails = 0;
  logic [31:0] m_ev = '0, m_mk = '0;
  logic [12:0] m_line = '0;

  always #2 clk = ~clk;

  eth_irq_unit uut (.*);

  function automatic int bitpos(input int l);
    int t [13] = '{27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30};
    return t[l];
  endfunction

  function automatic logic [12:0] to_lines(input logic [31:0] a);
    logic [12:0] r;
    for (int l = 0; l < 13; l++) r[l] = a[bitpos(l)];
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One bus cycle: drive at negedge, check before the edge, update model at edge
  task automatic step(input string tag, input logic wr, input logic [2:0] ad,
                      input logic [31:0] wd, input logic [12:0] pl);
    logic [31:0] setv, nev, nmk, rexp;
    @(negedge clk);
    bus_wr = wr; bus_addr = ad; bus_wdata = wd; ev_pulse = pl;
    #1;
    rexp = (ad == 3'd0) ? m_ev : (ad == 3'd1) ? m_mk : 32'h0;
    check({tag, " rdata"}, bus_rdata, rexp);
    check({tag, " lines R4"}, {19'h0, irq_line}, {19'h0, m_line});
    setv = '0;
    for (int l = 0; l < 13; l++) if (pl[l]) setv[bitpos(l)] = 1'b1;
    if (wr && ad == 3'd2) setv[23] = 1'b1;
    if (wr && ad == 3'd3 && wd[0]) setv[28] = 1'b1;
    if (wr && ad == 3'd4 && wd[0]) begin
      nev = '0; nmk = '0;
    end else begin
      nev = ((m_ev & ~((wr && ad == 3'd0) ? wd : 32'h0)) | setv) & 32'hFFF8_0000;
      nmk = (wr && ad == 3'd1) ? (wd & 32'hFFF8_0000) : m_mk;
    end
    @(posedge clk);
    m_line = to_lines(m_ev & m_mk);
    m_ev = nev; m_mk = nmk;
  endtask

  initial begin
    #400000;
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check("R12 event", uut.bus_rdata, 32'h0);
    check("R12 lines", {19'h0, irq_line}, 32'h0);
    rst_n = 1'b1;

    // R5: each line alone, fully enabled
    step("R3", 1, 3'd1, 32'hFFFF_FFFF, '0);
    for (int l = 0; l < 13; l++) begin
      step("R5 set", 0, 3'd0, 0, 13'(1) << l);
      step("R1", 0, 3'd0, 0, '0);
      step("R5 line", 0, 3'd0, 0, '0);
      check("R5 onehot", {19'h0, irq_line}, 32'(13'(1) << l));
      step("R2 clr", 1, 3'd0, 32'h1 << bitpos(l), '0);
    end
    // R10: all-ones into both registers
    step("R10", 1, 3'd1, 32'hFFFF_FFFF, 13'h1FFF);
    step("R10 read", 0, 3'd0, 0, '0);
    step("R10 mask", 0, 3'd1, 0, '0);
    // R9: clear and pulse of same bit together
    step("R9", 1, 3'd0, 32'hFFFF_FFFF, 13'h0040);
    step("R9 read", 0, 3'd0, 0, '0);
    step("R2 partial", 1, 3'd0, 32'h0800_0000, '0);
    // R6 / R7
    step("R6", 1, 3'd2, 32'h0, '0);
    step("R7 off", 1, 3'd3, 32'h0000_FFFE, '0);
    step("R7 on", 1, 3'd3, 32'h1, '0);
    step("R7 read", 0, 3'd0, 0, '0);
    // R11 unused addresses
    for (int a = 2; a < 8; a++) step("R11", 1, 3'(a), 32'hFFFF_FFFE, '0);
    step("R11 read", 0, 3'd5, 0, '0);
    // R8 with pulses in same cycle
    step("R8", 1, 3'd4, 32'h1, 13'h1FFF);
    step("R8 ev", 0, 3'd0, 0, '0);
    step("R8 mk", 0, 3'd1, 0, '0);
    step("R8 ln", 0, 3'd0, 0, '0);

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] ad;
      logic       wr;
      logic [31:0] wd;
      int r;
      r  = $urandom_range(0, 9);
      ad = (r < 4) ? 3'd0 : (r < 7) ? 3'd1 : 3'($urandom_range(0, 7));
      wr = ($urandom_range(0, 2) == 0);
      wd = $urandom;
      if (ad == 3'd4 && $urandom_range(0, 7) != 0) wd[0] = 1'b0;
      step("R1 random", wr, ad, wd, 13'($urandom) & 13'($urandom));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule